// File: doc/BRIEF.md
# Scanline IRQ Down-Counter

This block raises a raster interrupt after a programmed number of video address line A12 rising edges, which a picture processor produces about once per scanline. Software programs an 8-bit reload value, zeroes the counter, and enables or disables the interrupt, all through a CPU write port. Each accepted A12 rising edge either reloads the counter or decrements it. An interrupt request is raised when the count lands on zero.

The A12 input is asynchronous. It is synchronised to the system clock. A rising edge counts only if the line was low for at least three system clocks before it, so short glitches on the line are filtered out.

A revision-select input picks one of two zero-count rules. In the normal rule, any edge that leaves the count at zero fires, including a reload to zero. In the alternate rule, the edge fires only if the count was nonzero before the edge, or if an explicit clear was armed.

The CPU write port is a plain write strobe. It has no back-pressure: every cycle with `wr_valid` high is taken in that cycle.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset, `irq` is low. The reload value is 0xFF, the counter is 0, the interrupt is disabled and no clear is armed.
- R2: A write with address bits [15:13]=3'b110 and bit 0 = 0 stores `wr_data` as the reload value.
- R3: A write with address bits [15:13]=3'b110 and bit 0 = 1 sets the counter to 0. When `rev_alt`=1 it also arms a one-shot clear.
- R4: A write with address bits [15:13]=3'b111 and bit 0 = 0 disables the interrupt and drops `irq` on the next cycle. With bit 0 = 1, the same range enables the interrupt.
- R5: On an accepted A12 edge, the counter loads the reload value if it is 0 or if the clear is armed. Otherwise it decrements by one.
- R6: With `rev_alt`=0, an accepted edge that leaves the counter at 0 while the interrupt is enabled raises `irq`.
- R7: With `rev_alt`=1, an edge that leaves the counter at 0 raises `irq` only if the interrupt is enabled and either the count before the edge was nonzero or a clear was armed.
- R8: Every accepted A12 edge disarms the clear.
- R9: An A12 rising edge is accepted only if the synchronised line was low for at least 3 consecutive system clocks before it. Its effect is visible on `irq` within 3 clocks of the input rising.
- R10: Once raised, `irq` stays high until a disable write or reset. Enable writes and further edges do not drop it.
- R11: Writes with address bits [15:14] other than 2'b11 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU write strobe, taken every cycle it is high |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rev_alt | input | 1 | 1 selects the alternate zero-count rule |
| a12_in | input | 1 | Asynchronous video address line A12 |
| irq | output | 1 | Interrupt request, active high |

## Verification
The counter, reload value and armed clear are not visible at the ports. A wrong value in any of them shows up only as `irq` rising on the wrong A12 edge, or failing to rise. For a reload value N, the error appears no later than N+1 accepted edges after the state went wrong.

A filter that accepts too-short low periods, or rejects valid ones, shifts every later interrupt by one or more edges. The bench therefore models the counter edge by edge and compares `irq` three clocks after each rising edge and after every write.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic set_reload;
    logic clr_count;
    logic irq_off;
    logic irq_on;
  } wr_cmd_t;
endpackage

// File: rtl/a12_edge_filter.sv
module a12_edge_filter #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a12_in,
  output logic a12_edge
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

  logic sync1_q, sync2_q, prev_q;
  logic [CNT_W-1:0] low_cnt_q;

  // Synchroniser flops reset high, so no edge is seen until a real low period.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q   <= 1'b1;
      sync2_q   <= 1'b1;
      prev_q    <= 1'b1;
      low_cnt_q <= '0;
    end else begin
      sync1_q <= a12_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (sync2_q) low_cnt_q <= '0;
      else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign a12_edge = sync2_q && !prev_q && (low_cnt_q >= CNT_MAX);

  // R9: an accepted edge lasts exactly one cycle.
  p_edge_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a12_edge |=> !a12_edge);
endmodule

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import scan_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_cmd_t           cmd
);
  logic [2:0] top_bits;
  logic       odd;

  assign top_bits = wr_addr[ADDR_W-1 -: 3];
  assign odd      = wr_addr[0];

  always_comb begin
    cmd = '0;
    if (wr_valid) begin
      unique case (top_bits)
        3'b110:  if (odd) cmd.clr_count = 1'b1; else cmd.set_reload = 1'b1;
        3'b111:  if (odd) cmd.irq_on = 1'b1;    else cmd.irq_off = 1'b1;
        default: cmd = '0;
      endcase
    end
  end

  // R11: at most one command per write, and none outside the upper quarter.
  p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd));
  p_ignore_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr[ADDR_W-1 -: 2] != 2'b11) |-> (cmd == '0));
endmodule

// File: rtl/irq_down_counter.sv
module irq_down_counter
  import scan_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rev_alt,
  input  wr_cmd_t           cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              a12_edge,
  output logic              irq
);
  logic [DATA_W-1:0] reload_q, cnt_q, cnt_edge;
  logic              en_q, clr_q, pend_q;
  logic              reload_hit, fire;

  always_comb begin
    reload_hit = (cnt_q == '0) || clr_q;
    cnt_edge   = reload_hit ? reload_q : cnt_q - 1'b1;
    fire       = en_q && (cnt_edge == '0) &&
                 (!rev_alt || (cnt_q != '0) || clr_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '1;
      cnt_q    <= '0;
      en_q     <= 1'b0;
      clr_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (cmd.set_reload) reload_q <= wdata;
      if (cmd.clr_count) begin
        cnt_q <= '0;
        clr_q <= rev_alt;
      end else if (a12_edge) begin
        cnt_q <= cnt_edge;
        clr_q <= 1'b0;
      end
      if (cmd.irq_off)     en_q <= 1'b0;
      else if (cmd.irq_on) en_q <= 1'b1;
      if (cmd.irq_off)             pend_q <= 1'b0;
      else if (a12_edge && fire)   pend_q <= 1'b1;
    end
  end

  assign irq = pend_q;

  p_reload_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.set_reload |=> reload_q == $past(wdata));
  p_count_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr_count |=> cnt_q == '0);
  p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.irq_off |=> !irq);
  p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a12_edge && !cmd.clr_count && cnt_q != '0 && !clr_q)
      |=> cnt_q == DATA_W'($past(cnt_q) - 1'b1));
  p_clear_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (a12_edge && !cmd.clr_count) |=> !clr_q);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cmd.irq_off) |=> irq);
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scan_irq_pkg::*;
#(
  parameter int MIN_LOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rev_alt,
  input  logic              a12_in,
  output logic              irq
);
  wr_cmd_t cmd;
  logic    a12_edge;

  a12_edge_filter #(.MIN_LOW(MIN_LOW)) u_filter (
    .clk(clk), .rst_n(rst_n), .a12_in(a12_in), .a12_edge(a12_edge));

  irq_wr_decode u_decode (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .cmd(cmd));

  irq_down_counter u_counter (
    .clk(clk), .rst_n(rst_n), .rev_alt(rev_alt), .cmd(cmd), .wdata(wr_data),
    .a12_edge(a12_edge), .irq(irq));

  // R1: no request is pending on the first cycle after reset.
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !irq);
endmodule

// File: tb/scanline_irq_counter_bench.sv
module scanline_irq_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rev_alt = 1'b0;
  logic        a12_in = 1'b1;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] m_reload, m_cnt;
  logic       m_en, m_clr, m_pend;

  always #10 clk = ~clk;

  scanline_irq_counter u_scanline_irq_counter (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rev_alt(rev_alt), .a12_in(a12_in), .irq(irq));

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_fire(input logic alt, input logic [7:0] c_old,
                                      input logic clr, input logic [7:0] c_new,
                                      input logic en);
    return en && (c_new == 8'd0) && (!alt || (c_old != 8'd0) || clr);
  endfunction

  task automatic model_reset();
    m_reload = 8'hFF; m_cnt = 8'd0; m_en = 1'b0; m_clr = 1'b0; m_pend = 1'b0;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    if (a[15:13] == 3'b110) begin
      if (a[0]) begin m_cnt = 8'd0; m_clr = rev_alt; end
      else m_reload = d;
    end else if (a[15:13] == 3'b111) begin
      if (a[0]) m_en = 1'b1;
      else begin m_en = 1'b0; m_pend = 1'b0; end
    end
  endtask

  task automatic a12_pulse(input int low_n);
    logic [7:0] old_c;
    @(negedge clk);
    a12_in = 1'b0;
    repeat (low_n) @(negedge clk);
    a12_in = 1'b1;
    repeat (4) @(negedge clk);
    if (low_n >= 3) begin
      old_c = m_cnt;
      m_cnt = ((m_cnt == 8'd0) || m_clr) ? m_reload : m_cnt - 8'd1;
      if (model_fire(rev_alt, old_c, m_clr, m_cnt, m_en)) m_pend = 1'b1;
      m_clr = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: timeout actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", irq, 1'b0);

    // R1/R5: default reload 0xFF; enabled, first edge loads FF, no fire
    cpu_write(16'hE001, 8'h00);
    a12_pulse(5);
    check("R1 R5 load FF no fire", irq, m_pend);
    check("R5 expect low", irq, 1'b0);

    // R6: normal rule, reload 0 fires on reload-to-zero
    cpu_write(16'hC000, 8'h00);
    cpu_write(16'hC001, 8'h00);
    a12_pulse(4);
    check("R6 reload-to-zero fires", irq, 1'b1);
    // R10: enable write and edges keep it
    cpu_write(16'hE001, 8'h00);
    a12_pulse(4);
    check("R10 sticky", irq, 1'b1);
    // R4: disable drops
    cpu_write(16'hE000, 8'h00);
    check("R4 disable drops", irq, 1'b0);

    // R7: alternate rule, zero->zero reload without clear does not fire
    rev_alt = 1'b1;
    cpu_write(16'hE001, 8'h00);
    a12_pulse(4);
    check("R7 no fire without clear", irq, 1'b0);
    // R3/R7: armed clear makes it fire
    cpu_write(16'hC001, 8'h00);
    a12_pulse(4);
    check("R3 R7 clear fires", irq, 1'b1);
    cpu_write(16'hE000, 8'h00);
    cpu_write(16'hE001, 8'h00);
    // R8: clear gone after that edge, next zero->zero edge silent
    a12_pulse(4);
    check("R8 clear disarmed", irq, 1'b0);

    // R2/R5: reload 2 counts down, fires on third edge
    rev_alt = 1'b0;
    cpu_write(16'hC000, 8'h02);
    cpu_write(16'hC001, 8'h00);
    a12_pulse(3);
    check("R2 load 2", irq, 1'b0);
    a12_pulse(3);
    check("R5 dec to 1", irq, 1'b0);
    // R9: too-short low periods are ignored
    a12_pulse(2);
    a12_pulse(1);
    check("R9 short low ignored", irq, 1'b0);
    a12_pulse(3);
    check("R9 R5 reach zero fires", irq, 1'b1);
    cpu_write(16'hE000, 8'h00);

    // R11: writes outside upper quarter change nothing
    cpu_write(16'h8000, 8'h55);
    cpu_write(16'hA001, 8'h00);
    cpu_write(16'h6000, 8'h00);
    a12_pulse(4);
    check("R11 ignored writes", irq, m_pend);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [15:0] a;
      op = $urandom_range(0, 9);
      if (op == 9) rev_alt = $urandom_range(0, 1);
      else if (op >= 5) a12_pulse($urandom_range(1, 5));
      else begin
        case (op)
          0: a = {3'b110, 12'($urandom), 1'b0};
          1: a = {3'b110, 12'($urandom), 1'b1};
          2: a = {3'b111, 12'($urandom), 1'b0};
          3: a = {3'b111, 12'($urandom), 1'b1};
          default: a = {1'b0, 15'($urandom)};
        endcase
        cpu_write(a, 8'($urandom_range(0, 4)));
      end
      check("R5 R6 R7 R10 random", irq, m_pend);
    end

    // R1: reset mid-run clears request
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset again", irq, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule